// File: doc/BRIEF.md
# USB Line State and Speed Monitor

This block watches the two data lines of a low-/full-speed USB port. Both lines pass through one sample register clocked by the system clock. Each sample is then sorted into one of four line symbols: J, K, single-ended zero (SE0) or single-ended one (SE1). The meaning of a differential level depends on the speed in use, because J and K swap pin polarity between full speed and low speed.

The speed is either forced by a configuration input or learned from the bus. In automatic mode, the differential idle level seen when the bus leaves its power-up state, or when it comes out of an SE0 interval, decides the speed. D+ high means full speed and D- high means low speed.

Every SE0 interval is timed in clock cycles. When the interval ends, a long one gives a one-cycle bus-reset pulse. A medium one gives a one-cycle keep-alive pulse, but only while the bus runs at low speed. The duration limits are parameters derived from the clock frequency.

Top module: `usb_line_monitor`

## Requirements
- R1: `sym_o` reports 2 when both sampled lines are low (SE0) and 3 when both are high (SE1), whatever the speed.
- R2: For a differential sample, `sym_o` is 0 (J) or 1 (K). At full speed, J is D+ high with D- low. At low speed the polarity is the reverse, so J is D- high with D+ low. `sym_o` follows the pins one clock edge after they change.
- R3: `mode_sel` 1 forces full speed (`speed_low`=0) and 2 forces low speed (`speed_low`=1), and each takes effect at once. Values 0 and 3 select automatic detection.
- R4: In automatic mode, the first differential sample after power-up, or after an SE0 interval, sets the speed: `speed_low`=1 if D- is high and 0 if D+ is high. The new speed is visible two clock edges after the pins change.
- R5: An SE0 interval of more than RESET_CYC samples (CLK_HZ × 2.5 µs) gives exactly one `reset_pulse` cycle. The pulse is high after the second clock edge that follows the first non-SE0 level on the pins.
- R6: An SE0 interval of more than KEEP_CYC samples (CLK_HZ × 1.2 µs) and at most RESET_CYC samples gives exactly one `keepalive_pulse` cycle if the speed in use is low. At full speed it gives nothing.
- R7: An SE0 interval of at most KEEP_CYC samples gives neither pulse. The two pulses are never high together.
- R8: After reset, `speed_valid` stays 0, and no pulse is given, until a differential sample is seen. SE0 and SE1 levels keep the block waiting. Once `speed_valid` is 1 it stays 1.
- R9: An SE0 interval that ends in SE1 is still timed and reported, but it does not change the learned speed.
- R10: In automatic mode, J/K changes on the lines outside SE0 intervals never change the speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, frequency CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| dp | input | 1 | D+ line level |
| dm | input | 1 | D- line level |
| mode_sel | input | 2 | 0/3 automatic, 1 full speed, 2 low speed |
| sym_o | output | 2 | Line symbol: 0 J, 1 K, 2 SE0, 3 SE1 |
| speed_valid | output | 1 | Speed known (past the power-up wait) |
| speed_low | output | 1 | 1 low speed, 0 full speed |
| reset_pulse | output | 1 | One-cycle bus reset event |
| keepalive_pulse | output | 1 | One-cycle low-speed keep-alive event |

## Verification
SE0 bursts are driven at lengths on both sides of each limit (120/121 and 250/251 samples at 100 MHz). These lengths separate no event, keep-alive and reset, and show whether the limit compares as "greater than" or as "at least". The same medium burst is repeated at full speed, in forced low mode and in automatic low mode, which shows whether keep-alive depends on the speed in use. Idle levels are driven in both polarities after SE0, after SE1 and during plain J/K activity. These show which events may move the learned speed. They also show that the J/K code flips with the speed while the SE0 and SE1 codes do not.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;

  typedef enum logic [1:0] {
    SYM_J   = 2'd0,
    SYM_K   = 2'd1,
    SYM_SE0 = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_t;

  typedef enum logic [1:0] {
    MODE_AUTO  = 2'd0,
    MODE_FULL  = 2'd1,
    MODE_LOW   = 2'd2,
    MODE_AUTO2 = 2'd3
  } speed_mode_t;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_LINE = 2'd1,
    ST_SE0  = 2'd2
  } mon_state_t;

  // Line symbol of one sample; the J/K polarity flips at low speed.
  function automatic line_sym_t line_symbol(input logic p, input logic m, input logic low);
    case ({p, m})
      2'b00:   return SYM_SE0;
      2'b11:   return SYM_SE1;
      2'b10:   return low ? SYM_K : SYM_J;
      default: return low ? SYM_J : SYM_K;
    endcase
  endfunction

  // Clock cycles in a time given in tenths of a microsecond.
  function automatic int unsigned cycles_of(input longint unsigned hz,
                                            input longint unsigned tenths_us);
    longint unsigned prod;
    prod = (hz * tenths_us) / 64'd10_000_000;
    return int'(prod);
  endfunction

endpackage

// File: rtl/usb_lm_sampler.sv
module usb_lm_sampler
  import usb_lm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp,
  input  logic       dm,
  input  logic       speed_low,
  output logic       dp_q,
  output logic       is_se0,
  output logic       is_diff,
  output logic [1:0] sym
);

  logic dm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_q <= 1'b0;
      dm_q <= 1'b0;
    end else begin
      dp_q <= dp;
      dm_q <= dm;
    end
  end

  assign is_se0  = ~dp_q & ~dm_q;
  assign is_diff = dp_q ^ dm_q;
  assign sym     = line_symbol(dp_q, dm_q, speed_low);

  // R1: both lines low one edge earlier gives the SE0 code now
  a_r1_se0_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp && !dm) |=> (sym == SYM_SE0));

  // R2: a full-speed J level on the pins gives J one edge later
  a_r2_full_j: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && !dm && !speed_low) |=> (is_diff && (speed_low || sym == SYM_J)));

endmodule

// File: rtl/usb_lm_speed_ctl.sv
module usb_lm_speed_ctl
  import usb_lm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       is_se0,
  input  logic       is_diff,
  input  logic       dp_q,
  output logic       speed_low,
  output logic       speed_valid,
  output logic       se0_start,
  output logic       se0_run,
  output logic       se0_exit
);

  mon_state_t st;
  logic       learned_low;
  logic       force_full;
  logic       force_low;
  logic       auto_mode;
  logic       learn_now;

  assign force_full = (mode_sel == MODE_FULL);
  assign force_low  = (mode_sel == MODE_LOW);
  assign auto_mode  = ~force_full & ~force_low;
  assign learn_now  = is_diff & ((st == ST_INIT) | (st == ST_SE0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_INIT;
      learned_low <= 1'b0;
    end else begin
      case (st)
        ST_INIT: if (is_diff) st <= ST_LINE;
        ST_LINE: if (is_se0)  st <= ST_SE0;
        ST_SE0:  if (!is_se0) st <= ST_LINE;
        default: st <= ST_INIT;
      endcase
      if (force_low)      learned_low <= 1'b1;
      else if (force_full) learned_low <= 1'b0;
      else if (learn_now)  learned_low <= ~dp_q;
    end
  end

  assign speed_low   = force_low ? 1'b1 : (force_full ? 1'b0 : learned_low);
  assign speed_valid = (st != ST_INIT);
  assign se0_start   = (st == ST_LINE) & is_se0;
  assign se0_run     = (st == ST_SE0) & is_se0;
  assign se0_exit    = (st == ST_SE0) & ~is_se0;

  // R8: once past the power-up wait the speed stays valid
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    speed_valid |=> speed_valid);

  // R10: line activity outside SE0 leaves the learned speed alone
  a_r10_line_keeps_speed: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LINE && auto_mode) |=> $stable(learned_low));

  // R8: no SE0 interval is timed before the first differential level
  a_r8_no_se0_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_INIT) |-> !(se0_start || se0_exit));

endmodule

// File: rtl/usb_lm_se0_timer.sv
module usb_lm_se0_timer #(
  parameter int unsigned RESET_CYC = 250,
  parameter int unsigned KEEP_CYC  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0_start,
  input  logic se0_run,
  input  logic se0_exit,
  input  logic speed_low,
  output logic reset_pulse,
  output logic keepalive_pulse
);

  localparam int unsigned CW = $clog2(RESET_CYC + 2);
  localparam logic [CW-1:0] SAT_L   = CW'(RESET_CYC + 1);
  localparam logic [CW-1:0] RESET_L = CW'(RESET_CYC);
  localparam logic [CW-1:0] KEEP_L  = CW'(KEEP_CYC);

  logic [CW-1:0] cnt;
  logic          long_se0;
  logic          mid_se0;

  assign long_se0 = (cnt > RESET_L);
  assign mid_se0  = (cnt > KEEP_L) & ~long_se0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt             <= '0;
      reset_pulse     <= 1'b0;
      keepalive_pulse <= 1'b0;
    end else begin
      if (se0_start)                 cnt <= CW'(1);
      else if (se0_run && cnt != SAT_L) cnt <= cnt + CW'(1);
      reset_pulse     <= se0_exit & long_se0;
      keepalive_pulse <= se0_exit & mid_se0 & speed_low;
    end
  end

  // R5: a reset event lasts a single cycle
  a_r5_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse |=> !reset_pulse);

  // R6: keep-alive only when the speed in use was low
  a_r6_keep_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    keepalive_pulse |-> $past(speed_low));

  // R7: the two events never coincide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_pulse && keepalive_pulse));

  // R5: every event follows the end of an SE0 interval
  a_r5_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_pulse || keepalive_pulse) |-> $past(se0_exit));

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor #(
  parameter int unsigned CLK_HZ         = 48_000_000,
  parameter int unsigned RESET_TENTHS_US = 25,
  parameter int unsigned KEEP_TENTHS_US  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp,
  input  logic       dm,
  input  logic [1:0] mode_sel,
  output logic [1:0] sym_o,
  output logic       speed_valid,
  output logic       speed_low,
  output logic       reset_pulse,
  output logic       keepalive_pulse
);

  localparam int unsigned RESET_CYC = usb_lm_pkg::cycles_of(CLK_HZ, RESET_TENTHS_US);
  localparam int unsigned KEEP_CYC  = usb_lm_pkg::cycles_of(CLK_HZ, KEEP_TENTHS_US);

  logic dp_q, is_se0, is_diff;
  logic se0_start, se0_run, se0_exit;

  usb_lm_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp        (dp),
    .dm        (dm),
    .speed_low (speed_low),
    .dp_q      (dp_q),
    .is_se0    (is_se0),
    .is_diff   (is_diff),
    .sym       (sym_o)
  );

  usb_lm_speed_ctl u_speed (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .is_se0      (is_se0),
    .is_diff     (is_diff),
    .dp_q        (dp_q),
    .speed_low   (speed_low),
    .speed_valid (speed_valid),
    .se0_start   (se0_start),
    .se0_run     (se0_run),
    .se0_exit    (se0_exit)
  );

  usb_lm_se0_timer #(
    .RESET_CYC (RESET_CYC),
    .KEEP_CYC  (KEEP_CYC)
  ) u_timer (
    .clk             (clk),
    .rst_n           (rst_n),
    .se0_start       (se0_start),
    .se0_run         (se0_run),
    .se0_exit        (se0_exit),
    .speed_low       (speed_low),
    .reset_pulse     (reset_pulse),
    .keepalive_pulse (keepalive_pulse)
  );

endmodule

// File: tb/usb_line_monitor_bench.sv
`timescale 1ns/1ps
module usb_line_monitor_bench;

  localparam int unsigned HZ    = 100_000_000;
  localparam int          RST_N = 250;   // 2.5 us at 100 MHz
  localparam int          KA_N  = 120;   // 1.2 us at 100 MHz

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dp = 1'b0, dm = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [1:0] sym_o;
  logic speed_valid, speed_low, reset_pulse, keepalive_pulse;

  int n_cmp = 0, n_bad = 0;
  int rp_cnt = 0, ka_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  usb_line_monitor #(.CLK_HZ(HZ)) u_usb_line_monitor (
    .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .mode_sel(mode_sel),
    .sym_o(sym_o), .speed_valid(speed_valid), .speed_low(speed_low),
    .reset_pulse(reset_pulse), .keepalive_pulse(keepalive_pulse)
  );

  always @(negedge clk) if (rst_n) begin
    if (reset_pulse) rp_cnt++;
    if (keepalive_pulse) ka_cnt++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic p, input logic m);
    @(negedge clk); dp = p; dm = m;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // SE0 for n samples, then the exit level; returns pulse counts seen.
  task automatic se0_burst(input int n, input logic p, input logic m,
                           output int rp, output int ka);
    int r0, k0;
    r0 = rp_cnt; k0 = ka_cnt;
    drive(1'b0, 1'b0);
    wait_n(n);
    dp = p; dm = m;
    wait_n(4);
    rp = rp_cnt - r0; ka = ka_cnt - k0;
  endtask

  task automatic t_reset_state;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "sym in reset", sym_o, 2);
    chk("R8", "valid in reset", speed_valid, 0);
    chk("R8", "pulses in reset", reset_pulse | keepalive_pulse, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_power_up_wait;
    int rp, ka;
    se0_burst(300, 1'b1, 1'b1, rp, ka);
    chk("R8", "valid after SE0/SE1", speed_valid, 0);
    chk("R8", "no reset before valid", rp, 0);
    chk("R1", "SE1 code", sym_o, 3);
    drive(1'b0, 1'b1); wait_n(3);
    chk("R8", "valid after diff", speed_valid, 1);
    chk("R4", "learned low", speed_low, 1);
    chk("R2", "low-speed J", sym_o, 0);
    drive(1'b1, 1'b0); wait_n(3);
    chk("R2", "low-speed K", sym_o, 1);
    chk("R10", "K keeps low speed", speed_low, 1);
    drive(1'b0, 1'b1); wait_n(2);
  endtask

  task automatic t_low_durations;
    int rp, ka;
    se0_burst(KA_N + 1, 1'b0, 1'b1, rp, ka);
    chk("R6", "keep-alive at 121", ka, 1);
    chk("R6", "no reset at 121", rp, 0);
    se0_burst(RST_N, 1'b0, 1'b1, rp, ka);
    chk("R6", "keep-alive at 250", ka, 1);
    chk("R6", "no reset at 250", rp, 0);
    se0_burst(KA_N, 1'b0, 1'b1, rp, ka);
    chk("R7", "nothing at 120", rp + ka, 0);
    chk("R8", "valid stays", speed_valid, 1);
  endtask

  task automatic t_reset_timing;
    int r0;
    r0 = rp_cnt;
    drive(1'b0, 1'b0);
    wait_n(RST_N + 1);
    dp = 1'b1; dm = 1'b0;
    @(negedge clk);
    chk("R5", "no pulse one edge after exit", reset_pulse, 0);
    @(negedge clk);
    chk("R5", "pulse two edges after exit", reset_pulse, 1);
    chk("R7", "no keep-alive with reset", keepalive_pulse, 0);
    wait_n(3);
    chk("R5", "single reset pulse", rp_cnt - r0, 1);
    chk("R4", "full speed after reset", speed_low, 0);
    chk("R2", "full-speed J", sym_o, 0);
  endtask

  task automatic t_full_speed;
    int rp, ka;
    drive(1'b0, 1'b1); wait_n(3);
    chk("R2", "full-speed K", sym_o, 1);
    chk("R10", "K keeps full speed", speed_low, 0);
    drive(1'b1, 1'b0); wait_n(2);
    se0_burst(200, 1'b1, 1'b0, rp, ka);
    chk("R6", "no keep-alive at full", ka, 0);
    chk("R6", "no reset at 200", rp, 0);
    se0_burst(10, 1'b1, 1'b1, rp, ka);
    chk("R9", "SE1 exit no pulse", rp + ka, 0);
    drive(1'b0, 1'b1); wait_n(3);
    chk("R9", "SE1 exit keeps full", speed_low, 0);
    chk("R2", "K after SE1", sym_o, 1);
    se0_burst(400, 1'b1, 1'b1, rp, ka);
    chk("R9", "reset ending in SE1", rp, 1);
    chk("R9", "speed after SE1 reset", speed_low, 0);
    drive(1'b1, 1'b0); wait_n(2);
  endtask

  task automatic t_forced;
    int rp, ka;
    mode_sel = 2'd2; wait_n(1);
    chk("R3", "forced low", speed_low, 1);
    chk("R2", "D+ high at low is K", sym_o, 1);
    se0_burst(150, 1'b1, 1'b0, rp, ka);
    chk("R3", "forced low keep-alive", ka, 1);
    chk("R3", "forced low kept", speed_low, 1);
    mode_sel = 2'd1; wait_n(1);
    chk("R3", "forced full", speed_low, 0);
    se0_burst(10, 1'b0, 1'b1, rp, ka);
    chk("R3", "forced full ignores idle", speed_low, 0);
    mode_sel = 2'd3;
    se0_burst(10, 1'b0, 1'b1, rp, ka);
    chk("R4", "auto code 3 learns low", speed_low, 1);
    se0_burst(10, 1'b1, 1'b0, rp, ka);
    chk("R4", "auto code 3 learns full", speed_low, 0);
  endtask

  initial begin
    t_reset_state();
    t_power_up_wait();
    t_low_durations();
    t_reset_timing();
    t_full_speed();
    t_forced();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule